// File: doc/BRIEF.md
# Wake-Bit Serial Receiver

This block is an asynchronous serial receiver for a frame format that carries an extra wake-up bit after the data byte. The line rests high. A frame starts with one low start bit. Eight data bits follow, least significant bit first. The wake bit comes next, and one high stop bit ends the frame. The receiver oversamples the line on a 16x tick enable. It confirms a start bit at mid-bit and then samples each later bit at its centre. It delivers the byte and the wake bit on a valid/ready output stream, with a one-cycle receive interrupt pulse.

A skip mode lets software ignore traffic that is meant for other stations on a shared line. While skip is enabled, frames that carry a wake bit of 0 are dropped. The first good frame with a wake bit of 1 is delivered and turns skip off in hardware, so the frames that follow are received normally. Software checks the delivered ID byte. If the ID is not its own, software sets skip again. Two sticky flags report errors: one for a stop bit sampled low, and one for a frame that arrives while the previous byte has not been taken.

Back-pressure rules: `rx_valid` acts as the full flag. It stays high, with `rx_data` and `rx_mpb` held stable, until `rx_ready` is seen high. A frame that is accepted while `rx_valid` is high and `rx_ready` is low is lost. It raises the overrun flag, and the old byte is kept. A frame that completes in the same cycle that `rx_ready` is high replaces the byte without an overrun.

Top module: `mpuart_rx`

## Requirements
- R1: A frame is a low start bit, data bits D0..D7 sent least significant bit first, then the wake bit, then the stop bit. A good delivered frame presents D7..D0 on `rx_data[7:0]`.
- R2: A start bit is recognised only on a high-to-low change seen on ticks. It is confirmed by a low sample on the 8th tick after it is recognised. A low pulse shorter than that delivers nothing.
- R3: While `skip_en` is 1, a good frame with a wake bit of 0 leaves `rx_data` unchanged, leaves `rx_valid` low and raises no `rx_irq`.
- R4: While `skip_en` is 1, a good frame with a wake bit of 1 is loaded, sets `rx_valid` and pulses `rx_irq` for one cycle.
- R5: A good frame with a wake bit of 1 clears `skip_en` to 0.
- R6: While `skip_en` is 0, every good frame is loaded, sets `rx_valid` and pulses `rx_irq`, whatever its wake bit.
- R7: `rx_valid` stays high with stable data until a cycle with `rx_ready` high, and then it falls.
- R8: A stop bit sampled low sets `frm_err` and does not update `rx_data` or `rx_valid`.
- R9: A frame accepted while `rx_valid` is high and `rx_ready` is low sets `ovr_err` and keeps the old byte.
- R10: The wake bit of the loaded frame appears on `rx_mpb` along with the data.
- R11: A `skip_wr` in the same cycle as the hardware clear wins, so `skip_en` takes `skip_wdata`.
- R12: A pulse on `err_clr` clears both `frm_err` and `ovr_err`.
- R13: The line is sampled only in cycles where `tick16` is high. A frame sent with ticks every third cycle is received the same way as one sent with ticks every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial line, idles high |
| tick16 | input | 1 | 16x oversample enable |
| skip_wr | input | 1 | Write strobe for the skip-enable bit |
| skip_wdata | input | 1 | Value to write to skip-enable |
| err_clr | input | 1 | Clears both error flags |
| rx_ready | input | 1 | Consumer takes the byte (clears full) |
| rx_valid | output | 1 | Byte held (full flag) |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Wake bit of the held byte |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| skip_en | output | 1 | Skip-enable state |
| frm_err | output | 1 | Sticky framing-error flag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach from the ports is a software write of skip-enable that lands in the same cycle as the hardware clear. That cycle lies deep inside the stop-bit timing. The stimulus holds `skip_wr` high, with a write value of 1, across a whole wake frame, so the write is present in whatever cycle the clear occurs. The bench then expects the byte to be delivered while `skip_en` still reads 1. Overrun is reached by sending two frames without asserting `rx_ready`. Start-bit confirmation is exercised with a low pulse that is too short to be a start bit.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mpuart_sampler.sv
module mpuart_sampler
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              mpb,
  output logic              stop_ok
);
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int CNT_W      = $clog2(OSR);
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e             state;
  logic [CNT_W-1:0]      cnt;
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] sh;
  logic                  prev;

  assign data = sh[DATA_W-1:0];
  assign mpb  = sh[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      prev    <= 1'b1;
      done    <= 1'b0;
      stop_ok <= 1'b1;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= rxd;
        unique case (state)
          RX_IDLE: if (!rxd && prev) begin
            state <= RX_START;
            cnt   <= '0;
          end
          RX_START: if (cnt == MID) begin
            cnt   <= '0;
            idx   <= '0;
            state <= rxd ? RX_IDLE : RX_BITS;
          end else cnt <= cnt + 1'b1;
          RX_BITS: if (cnt == LAST) begin
            cnt <= '0;
            sh  <= {rxd, sh[FRAME_BITS-1:1]};
            if (idx == IDX_W'(FRAME_BITS - 1)) state <= RX_STOP;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          RX_STOP: if (cnt == LAST) begin
            done    <= 1'b1;
            stop_ok <= rxd;
            state   <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mpuart_accept.sv
module mpuart_accept #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_mpb,
  input  logic              fr_stop_ok,
  input  logic              rdy,
  input  logic              skip_wr,
  input  logic              skip_wdata,
  input  logic              err_clr,
  output logic              valid,
  output logic [DATA_W-1:0] rdata,
  output logic              rmpb,
  output logic              irq,
  output logic              skip_en,
  output logic              frm_err,
  output logic              ovr_err
);
  logic good, take, lost, load, hw_clr;

  always_comb begin
    good   = done && fr_stop_ok;
    take   = good && (!skip_en || fr_mpb);
    lost   = take && valid && !rdy;
    load   = take && !lost;
    hw_clr = good && fr_mpb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      rdata   <= '0;
      rmpb    <= 1'b0;
      irq     <= 1'b0;
      skip_en <= 1'b0;
      frm_err <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      irq <= load;
      if (load) begin
        rdata <= fr_data;
        rmpb  <= fr_mpb;
        valid <= 1'b1;
      end else if (rdy) begin
        valid <= 1'b0;
      end
      if (skip_wr)     skip_en <= skip_wdata;
      else if (hw_clr) skip_en <= 1'b0;
      if (done && !fr_stop_ok) frm_err <= 1'b1;
      else if (err_clr)        frm_err <= 1'b0;
      if (lost)                ovr_err <= 1'b1;
      else if (err_clr)        ovr_err <= 1'b0;
    end
  end

  // R3
  skip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fr_stop_ok && skip_en && !fr_mpb |=> $stable(rdata) && !irq);
  // R4
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> valid);
  // R5
  skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fr_stop_ok && fr_mpb && !skip_wr |=> !skip_en);
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !rdy |=> valid && $stable(rdata));
  // R8
  frm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fr_stop_ok |=> frm_err && $stable(rdata));
  // R9
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fr_stop_ok && !skip_en && valid && !rdy |=> ovr_err && $stable(rdata));
  // R11
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_wr |=> skip_en == $past(skip_wdata));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick16,
  input  logic              skip_wr,
  input  logic              skip_wdata,
  input  logic              err_clr,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_irq,
  output logic              skip_en,
  output logic              frm_err,
  output logic              ovr_err
);
  logic              f_done, f_mpb, f_stop_ok;
  logic [DATA_W-1:0] f_data;

  mpuart_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
    .done(f_done), .data(f_data), .mpb(f_mpb), .stop_ok(f_stop_ok)
  );

  mpuart_accept #(.DATA_W(DATA_W)) u_accept (
    .clk(clk), .rst_n(rst_n), .done(f_done), .fr_data(f_data),
    .fr_mpb(f_mpb), .fr_stop_ok(f_stop_ok), .rdy(rx_ready),
    .skip_wr(skip_wr), .skip_wdata(skip_wdata), .err_clr(err_clr),
    .valid(rx_valid), .rdata(rx_data), .rmpb(rx_mpb), .irq(rx_irq),
    .skip_en(skip_en), .frm_err(frm_err), .ovr_err(ovr_err)
  );
endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick16 = 1'b0;
  logic skip_wr = 1'b0, skip_wdata = 1'b0, err_clr = 1'b0, rx_ready = 1'b0;
  logic rx_valid, rx_mpb, rx_irq, skip_en, frm_err, ovr_err;
  logic [7:0] rx_data;
  int nchk = 0, nerr = 0, irqn = 0, div = 1, tcnt = 0;
  logic [7:0] exp_data = 8'h00;
  logic exp_mpb = 1'b0;

  // fields: [19] skip before, [18:11] data, [10] wake bit, [9] stop,
  // [8] expect load, [7] skip after, [6] expect frm_err
  localparam logic [19:0] VEC [7] = '{
    {1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0},
    {1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0},
    {1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0},
    {1'b1, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0},
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0},
    {1'b0, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0}
  };

  mpuart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .skip_wr(skip_wr),
    .skip_wdata(skip_wdata), .err_clr(err_clr), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_irq(rx_irq),
    .skip_en(skip_en), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= div - 1) tcnt = 0; else tcnt = tcnt + 1;
    tick16 = (tcnt == 0);
    if (rx_irq) irqn = irqn + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_bit();
    repeat (16 * div) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic m, input logic s);
    rxd = 1'b0; hold_bit();
    for (int i = 0; i < 8; i++) begin rxd = d[i]; hold_bit(); end
    rxd = m; hold_bit();
    rxd = s; hold_bit();
    rxd = 1'b1; repeat (8 * div + 4) @(negedge clk);
  endtask

  task automatic pulse_ready();
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  task automatic write_skip(input logic v);
    skip_wdata = v; skip_wr = 1'b1; @(negedge clk); skip_wr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int i0;
    repeat (4) @(negedge clk);
    chk(rx_valid == 0 && skip_en == 0 && frm_err == 0 && ovr_err == 0 && rx_irq == 0,
        "reset state", {rx_valid, skip_en, frm_err, ovr_err}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      logic [19:0] e;
      e = VEC[v];
      write_skip(e[19]);
      i0 = irqn;
      send(e[18:11], e[10], e[9]);
      if (e[8]) begin exp_data = e[18:11]; exp_mpb = e[10]; end
      // R1 R3 R4 R6
      chk(rx_valid == e[8], "R3/R4/R6 valid", rx_valid, e[8]);
      chk(rx_data == exp_data, "R1 data", rx_data, exp_data);
      // R10
      chk(rx_mpb == exp_mpb, "R10 wake bit", rx_mpb, exp_mpb);
      chk(irqn - i0 == int'(e[8]), "R4 irq count", irqn - i0, e[8]);
      // R5
      chk(skip_en == e[7], "R5 skip state", skip_en, e[7]);
      // R8
      chk(frm_err == e[6], "R8 frm_err", frm_err, e[6]);
      pulse_ready();
      // R7
      chk(rx_valid == 0, "R7 valid after ready", rx_valid, 0);
      pulse_clr();
    end

    // R2: short low glitch
    i0 = irqn;
    rxd = 1'b0; repeat (4) @(negedge clk);
    rxd = 1'b1; repeat (300) @(negedge clk);
    chk(irqn == i0 && rx_valid == 0, "R2 glitch ignored", irqn - i0, 0);

    // R9: overrun keeps old byte
    send(8'hA1, 1'b0, 1'b1);
    send(8'h7E, 1'b0, 1'b1);
    chk(ovr_err == 1, "R9 overrun flag", ovr_err, 1);
    chk(rx_data == 8'hA1, "R9 old byte kept", rx_data, 8'hA1);
    chk(rx_valid == 1, "R7 valid held", rx_valid, 1);
    // R12
    pulse_clr();
    chk(ovr_err == 0 && frm_err == 0, "R12 flags cleared", {ovr_err, frm_err}, 0);
    pulse_ready();

    // R11: write held through the hardware clear
    skip_wdata = 1'b1; skip_wr = 1'b1;
    send(8'h99, 1'b1, 1'b1);
    chk(rx_data == 8'h99 && rx_valid == 1, "R11 wake frame loaded", rx_data, 8'h99);
    chk(skip_en == 1, "R11 write wins", skip_en, 1);
    skip_wr = 1'b0; @(negedge clk);
    pulse_ready();
    write_skip(1'b0);

    // R13: sparse ticks
    div = 3;
    repeat (6) @(negedge clk);
    send(8'h6B, 1'b1, 1'b1);
    chk(rx_data == 8'h6B && rx_valid == 1, "R13 sparse tick data", rx_data, 8'h6B);
    chk(rx_mpb == 1, "R13 sparse tick wake bit", rx_mpb, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule